// File: doc/BRIEF.md
# Variable-Length Instruction Format Classifier

This block sits behind an instruction byte fetcher and turns a stream of bytes, one per cycle, into decoded instruction records. It finds each instruction's length from the opcode's high nibble. For the opcodes that nibble leaves open, it looks at the addressing flag bits in the first and second bytes. It then gathers one to four bytes and emits one record with a single-cycle valid pulse.

The record carries the following:
- a two-bit format code;
- a flag that marks legacy three-byte instructions;
- the opcode, with its two low bits cleared where those bits carry flags;
- the two register numbers used by two-byte instructions;
- the six addressing flags;
- a displacement or address field of up to 20 bits.

Every field that a format does not use reads zero. The block does not interpret opcodes, form target addresses or fetch operands. The byte after a final byte is always taken as the start of the next instruction, so instructions stream back to back with no bubble.

Top module: `insn_fmt_classifier`

## Requirements
- R1: A first byte whose high nibble is 0xC or 0xF is a complete one-byte instruction. The record has format code 0 and opcode equal to that byte.
- R2: A first byte whose high nibble is 0x9, 0xA or 0xB starts a two-byte instruction. The record has format code 1 and opcode equal to the first byte. r1 is the second byte's bits 7:4 and r2 is its bits 3:0.
- R3: For every other first byte, the record opcode is that byte with bits 1:0 cleared. Flag n is the first byte's bit 1 and flag i is its bit 0.
- R4: When n and i are both 0, the instruction is three bytes long. The record has format code 2 and the legacy flag set. Flag x is the second byte's bit 7, and b, p and e read 0. The field is a 15-bit value: the second byte's bits 6:0 followed by the third byte.
- R5: When n and i are not both 0 and the second byte's bit 4 (e) is 0, the instruction is three bytes long with format code 2. x, b, p and e are the second byte's bits 7, 6, 5 and 4. The field is the second byte's bits 3:0 followed by the third byte, zero-extended.
- R6: When n and i are not both 0 and e is 1, the instruction is four bytes long with format code 3. The field is the second byte's bits 3:0 followed by the third and fourth bytes.
- R7: rec_valid_o is high for exactly the one cycle after the edge at which an instruction's final byte is accepted, and it is low in every other cycle.
- R8: in_ready_o is always high. Cycles with in_valid_i low hold the collection state. A byte accepted in the same cycle as a record is emitted is the first byte of the next instruction.
- R9: The register fields, flags and field bits that a format does not define read zero in its record.
- R10: Reset clears rec_valid_o and discards a partially collected instruction. The first byte after reset starts a new instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input byte present |
| in_byte_i | input | 8 | Instruction byte |
| in_ready_o | output | 1 | Byte acceptance, always high |
| rec_valid_o | output | 1 | Record valid pulse |
| rec_fmt_o | output | 2 | Format code: 0 to 3 for one- to four-byte instructions |
| rec_legacy_o | output | 1 | Legacy three-byte instruction (n=i=0) |
| rec_opcode_o | output | 8 | Opcode; bits 1:0 are cleared for formats 2 and 3 |
| rec_r1_o | output | 4 | First register number (format code 1) |
| rec_r2_o | output | 4 | Second register number (format code 1) |
| rec_n_o | output | 1 | Indirect flag |
| rec_i_o | output | 1 | Immediate flag |
| rec_x_o | output | 1 | Index flag |
| rec_b_o | output | 1 | Base-relative flag |
| rec_p_o | output | 1 | PC-relative flag |
| rec_e_o | output | 1 | Extended-length flag |
| rec_field_o | output | 20 | Displacement or address, zero-extended |

## Verification
The assertions assume that bytes arrive on in_valid_i with no framing information. They also assume that the first byte after reset is an instruction's first byte. Under those assumptions every record must be consistent in itself, whatever the byte values are. Any record must also follow a cycle in which a byte was accepted.

The stimulus keeps within these assumptions. It only sends complete instructions, except in one case: a deliberate reset in the middle of an instruction, which the assumption on the first byte after reset covers. Every possible first byte is paired with second bytes that set and clear e. Idle cycles are inserted at varying byte positions to check that gaps hold the collection state.

// File: rtl/insn_fmt_pkg.sv
package insn_fmt_pkg;
  localparam int BYTE_W  = 8;
  localparam int NIB_W   = 4;
  localparam int FIELD_W = 20;
  localparam int MAX_LEN = 4;
  localparam int CNT_W   = $clog2(MAX_LEN);
  localparam int LEN_W   = $clog2(MAX_LEN + 1);

  typedef enum logic [1:0] {
    FMT_ONE   = 2'd0,
    FMT_TWO   = 2'd1,
    FMT_THREE = 2'd2,
    FMT_FOUR  = 2'd3
  } fmt_e;

  typedef struct packed {
    fmt_e               fmt;
    logic               legacy;
    logic [BYTE_W-1:0]  opcode;
    logic [NIB_W-1:0]   r1;
    logic [NIB_W-1:0]   r2;
    logic               n;
    logic               i;
    logic               x;
    logic               b;
    logic               p;
    logic               e;
    logic [FIELD_W-1:0] field;
  } rec_t;
endpackage

// File: rtl/insn_len_resolve.sv
module insn_len_resolve
  import insn_fmt_pkg::*;
(
  input  logic [BYTE_W-1:0] head_i,
  input  logic [BYTE_W-1:0] mode_i,
  output fmt_e              fmt_o,
  output logic              legacy_o,
  output logic [LEN_W-1:0]  len_o
);
  always_comb begin
    fmt_o    = FMT_THREE;
    legacy_o = 1'b0;
    len_o    = LEN_W'(3);
    unique case (head_i[7:4])
      4'hC, 4'hF: begin
        fmt_o = FMT_ONE;
        len_o = LEN_W'(1);
      end
      4'h9, 4'hA, 4'hB: begin
        fmt_o = FMT_TWO;
        len_o = LEN_W'(2);
      end
      default: begin
        if (head_i[1:0] == 2'b00) begin
          legacy_o = 1'b1;
        end else if (mode_i[4]) begin
          fmt_o = FMT_FOUR;
          len_o = LEN_W'(4);
        end
      end
    endcase
  end
endmodule

// File: rtl/insn_byte_gather.sv
module insn_byte_gather
  import insn_fmt_pkg::*;
(
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           take_i,
  input  logic                           last_i,
  input  logic [BYTE_W-1:0]              byte_i,
  output logic [CNT_W-1:0]               cnt_o,
  output logic [MAX_LEN-1:0][BYTE_W-1:0] view_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] hold_q [MAX_LEN-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (take_i) cnt_q <= last_i ? '0 : cnt_q + CNT_W'(1);
  end

  for (genvar k = 0; k < MAX_LEN; k++) begin : g_slot
    if (k < MAX_LEN - 1) begin : g_held
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                hold_q[k] <= '0;
        else if (take_i && cnt_q == CNT_W'(k))      hold_q[k] <= byte_i;
      end
      // incoming byte overlays its own slot so the record forms in the accept cycle
      assign view_o[k] = (cnt_q == CNT_W'(k)) ? byte_i : hold_q[k];
    end else begin : g_tail
      assign view_o[k] = (cnt_q == CNT_W'(k)) ? byte_i : '0;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/insn_rec_pack.sv
module insn_rec_pack
  import insn_fmt_pkg::*;
(
  input  fmt_e                           fmt_i,
  input  logic                           legacy_i,
  input  logic [MAX_LEN-1:0][BYTE_W-1:0] view_i,
  output rec_t                           rec_o
);
  always_comb begin
    rec_o        = '0;
    rec_o.fmt    = fmt_i;
    rec_o.legacy = legacy_i;
    unique case (fmt_i)
      FMT_ONE: rec_o.opcode = view_i[0];
      FMT_TWO: begin
        rec_o.opcode = view_i[0];
        rec_o.r1     = view_i[1][7:4];
        rec_o.r2     = view_i[1][3:0];
      end
      default: begin
        rec_o.opcode = {view_i[0][7:2], 2'b00};
        rec_o.x      = view_i[1][7];
        if (legacy_i) begin
          rec_o.field = FIELD_W'({view_i[1][6:0], view_i[2]});
        end else begin
          rec_o.n = view_i[0][1];
          rec_o.i = view_i[0][0];
          rec_o.b = view_i[1][6];
          rec_o.p = view_i[1][5];
          rec_o.e = view_i[1][4];
          if (fmt_i == FMT_FOUR)
            rec_o.field = {view_i[1][3:0], view_i[2], view_i[3]};
          else
            rec_o.field = FIELD_W'({view_i[1][3:0], view_i[2]});
        end
      end
    endcase
  end
endmodule

// File: rtl/insn_fmt_classifier.sv
module insn_fmt_classifier
  import insn_fmt_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_valid_i,
  input  logic [BYTE_W-1:0]   in_byte_i,
  output logic                in_ready_o,
  output logic                rec_valid_o,
  output logic [1:0]          rec_fmt_o,
  output logic                rec_legacy_o,
  output logic [BYTE_W-1:0]   rec_opcode_o,
  output logic [NIB_W-1:0]    rec_r1_o,
  output logic [NIB_W-1:0]    rec_r2_o,
  output logic                rec_n_o,
  output logic                rec_i_o,
  output logic                rec_x_o,
  output logic                rec_b_o,
  output logic                rec_p_o,
  output logic                rec_e_o,
  output logic [FIELD_W-1:0]  rec_field_o
);
  logic                           take;
  logic                           last;
  logic [CNT_W-1:0]               cnt;
  logic [MAX_LEN-1:0][BYTE_W-1:0] view;
  fmt_e                           fmt;
  logic                           legacy;
  logic [LEN_W-1:0]               len;
  rec_t                           rec_d, rec_q;
  logic                           valid_q;

  assign in_ready_o = 1'b1;
  assign take       = in_valid_i;
  assign last       = (LEN_W'(cnt) + LEN_W'(1)) == len;

  insn_byte_gather u_gather (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .take_i (take),
    .last_i (last),
    .byte_i (in_byte_i),
    .cnt_o  (cnt),
    .view_o (view)
  );

  insn_len_resolve u_len (
    .head_i   (view[0]),
    .mode_i   (view[1]),
    .fmt_o    (fmt),
    .legacy_o (legacy),
    .len_o    (len)
  );

  insn_rec_pack u_pack (
    .fmt_i    (fmt),
    .legacy_i (legacy),
    .view_i   (view),
    .rec_o    (rec_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      rec_q   <= '0;
    end else begin
      valid_q <= take && last;
      if (take && last) rec_q <= rec_d;
    end
  end

  assign rec_valid_o  = valid_q;
  assign rec_fmt_o    = rec_q.fmt;
  assign rec_legacy_o = rec_q.legacy;
  assign rec_opcode_o = rec_q.opcode;
  assign rec_r1_o     = rec_q.r1;
  assign rec_r2_o     = rec_q.r2;
  assign rec_n_o      = rec_q.n;
  assign rec_i_o      = rec_q.i;
  assign rec_x_o      = rec_q.x;
  assign rec_b_o      = rec_q.b;
  assign rec_p_o      = rec_q.p;
  assign rec_e_o      = rec_q.e;
  assign rec_field_o  = rec_q.field;
endmodule

// File: rtl/insn_fmt_classifier_chk.sv
module insn_fmt_classifier_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_valid_i,
  input logic        in_ready_o,
  input logic        rec_valid_o,
  input logic [1:0]  rec_fmt_o,
  input logic        rec_legacy_o,
  input logic [7:0]  rec_opcode_o,
  input logic [3:0]  rec_r1_o,
  input logic [3:0]  rec_r2_o,
  input logic        rec_n_o,
  input logic        rec_i_o,
  input logic        rec_x_o,
  input logic        rec_b_o,
  input logic        rec_p_o,
  input logic        rec_e_o,
  input logic [19:0] rec_field_o
);
  logic [5:0] flags;
  assign flags = {rec_n_o, rec_i_o, rec_x_o, rec_b_o, rec_p_o, rec_e_o};

  a_r1_one_byte_nibble: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && rec_fmt_o == 2'd0 |-> rec_opcode_o[7:4] == 4'hC || rec_opcode_o[7:4] == 4'hF);

  a_r2_two_byte_nibble: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && rec_fmt_o == 2'd1 |->
      rec_opcode_o[7:4] == 4'h9 || rec_opcode_o[7:4] == 4'hA || rec_opcode_o[7:4] == 4'hB);

  a_r3_opcode_low_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && rec_fmt_o[1] |-> rec_opcode_o[1:0] == 2'b00);

  a_r4_legacy_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && rec_legacy_o |->
      rec_fmt_o == 2'd2 && flags[5:4] == 2'b00 && flags[2:0] == 3'b000 && rec_field_o[19:15] == 5'd0);

  a_r5_short_disp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && rec_fmt_o == 2'd2 && !rec_legacy_o |->
      !rec_e_o && (rec_n_o || rec_i_o) && rec_field_o[19:12] == 8'd0);

  a_r6_long_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && rec_fmt_o == 2'd3 |-> rec_e_o && !rec_legacy_o && (rec_n_o || rec_i_o));

  a_r7_follows_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> $past(in_valid_i));

  a_r8_ready_high: assert property (@(posedge clk_i) disable iff (!rst_ni) in_ready_o);

  a_r9_short_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && !rec_fmt_o[1] |-> flags == 6'd0 && rec_field_o == 20'd0 && !rec_legacy_o &&
      (rec_fmt_o == 2'd1 || (rec_r1_o == 4'd0 && rec_r2_o == 4'd0)));

  a_r9_long_regs_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && rec_fmt_o[1] |-> rec_r1_o == 4'd0 && rec_r2_o == 4'd0);
endmodule

bind insn_fmt_classifier insn_fmt_classifier_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .in_valid_i   (in_valid_i),
  .in_ready_o   (in_ready_o),
  .rec_valid_o  (rec_valid_o),
  .rec_fmt_o    (rec_fmt_o),
  .rec_legacy_o (rec_legacy_o),
  .rec_opcode_o (rec_opcode_o),
  .rec_r1_o     (rec_r1_o),
  .rec_r2_o     (rec_r2_o),
  .rec_n_o      (rec_n_o),
  .rec_i_o      (rec_i_o),
  .rec_x_o      (rec_x_o),
  .rec_b_o      (rec_b_o),
  .rec_p_o      (rec_p_o),
  .rec_e_o      (rec_e_o),
  .rec_field_o  (rec_field_o)
);

// File: tb/insn_fmt_classifier_test.sv
module insn_fmt_classifier_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [7:0]  in_byte_i = '0;
  logic        in_ready_o, rec_valid_o, rec_legacy_o;
  logic [1:0]  rec_fmt_o;
  logic [7:0]  rec_opcode_o;
  logic [3:0]  rec_r1_o, rec_r2_o;
  logic        rec_n_o, rec_i_o, rec_x_o, rec_b_o, rec_p_o, rec_e_o;
  logic [19:0] rec_field_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit pend   = 0;
  logic [44:0] pend_exp = '0;
  string pend_tag = "";

  always #2 clk_i = ~clk_i;

  insn_fmt_classifier uut (.*);

  function automatic logic [44:0] got_rec();
    return {rec_fmt_o, rec_legacy_o, rec_opcode_o, rec_r1_o, rec_r2_o,
            rec_n_o, rec_i_o, rec_x_o, rec_b_o, rec_p_o, rec_e_o, rec_field_o};
  endfunction

  // reference record from the requirements, arithmetic only
  function automatic logic [44:0] model(input int b0, input int b1, input int b2, input int b3,
                                        output int len, output string tag);
    int fmt = 0, leg = 0, op = 0, r1 = 0, r2 = 0, fld = 0;
    int n = 0, i = 0, x = 0, b = 0, p = 0, e = 0;
    int nib = b0 / 16;
    if (nib == 12 || nib == 15) begin
      len = 1; tag = "R1"; op = b0;                              // R1, R9
    end else if (nib >= 9 && nib <= 11) begin
      len = 2; tag = "R2"; fmt = 1; op = b0; r1 = b1 / 16; r2 = b1 % 16;
    end else begin
      op = b0 - (b0 % 4); fmt = 2; len = 3; x = b1 / 128;        // R3
      if (b0 % 4 == 0) begin
        tag = "R4"; leg = 1; fld = (b1 % 128) * 256 + b2;
      end else begin
        n = (b0 / 2) % 2; i = b0 % 2;
        b = (b1 / 64) % 2; p = (b1 / 32) % 2; e = (b1 / 16) % 2;
        if (e == 1) begin
          tag = "R6"; fmt = 3; len = 4; fld = (b1 % 16) * 65536 + b2 * 256 + b3;
        end else begin
          tag = "R5"; fld = (b1 % 16) * 256 + b2;
        end
      end
    end
    return {fmt[1:0], leg[0], op[7:0], r1[3:0], r2[3:0], n[0], i[0], x[0], b[0], p[0], e[0], fld[19:0]};
  endfunction

  task automatic step(input logic v, input logic [7:0] d, input bit fin,
                      input logic [44:0] exp, input string tag);
    @(negedge clk_i);
    checks++;
    if (!in_ready_o) begin
      fails++; $display("FAIL R8 ready got %0b exp 1", in_ready_o);
    end
    checks++;
    if (pend) begin
      if (!rec_valid_o || got_rec() !== pend_exp) begin
        fails++;
        $display("FAIL %s/R7 valid %0b rec got %h exp %h", pend_tag, rec_valid_o, got_rec(), pend_exp);
      end
    end else if (rec_valid_o !== 1'b0) begin
      fails++; $display("FAIL R7 spurious valid got %0b exp 0", rec_valid_o);
    end
    in_valid_i = v;
    in_byte_i  = d;
    pend       = v && fin;
    pend_exp   = exp;
    pend_tag   = tag;
  endtask

  initial begin
    int len;
    string tag;
    logic [44:0] exp;
    repeat (3) @(negedge clk_i);
    checks++;
    if (rec_valid_o !== 1'b0 || in_ready_o !== 1'b1) begin
      fails++; $display("FAIL R10 reset valid/ready got %0b%0b exp 01", rec_valid_o, in_ready_o);
    end
    rst_ni = 1'b1;
    // R1-style sweep: every first byte, second byte chosen to set and clear e
    for (int b0 = 0; b0 < 256; b0++) begin
      for (int sel = 0; sel < 4; sel++) begin
        int bs [4];
        bs[0] = b0;
        bs[1] = (((b0 ^ 8'h5A) + sel * 8'h4B) & 8'hEF) | ((sel % 2) * 16);
        bs[2] = 255 - b0;
        bs[3] = (b0 * 7 + sel) % 256;
        exp = model(bs[0], bs[1], bs[2], bs[3], len, tag);
        for (int j = 0; j < len; j++) begin
          if ((b0 + sel + j) % 7 == 3) step(1'b0, 8'hFF, 0, '0, "R8");   // R8 gap holds state
          step(1'b1, bs[j][7:0], j == len - 1, exp, tag);
        end
      end
    end
    step(1'b0, 8'h00, 0, '0, "R7");
    // R10: reset during a partly collected instruction
    step(1'b1, 8'h03, 0, '0, "R10");
    step(1'b0, 8'h00, 0, '0, "R10");
    rst_ni = 1'b0;
    @(negedge clk_i);
    checks++;
    if (rec_valid_o !== 1'b0) begin
      fails++; $display("FAIL R10 valid in reset got %0b exp 0", rec_valid_o);
    end
    rst_ni = 1'b1;
    exp = model(8'hC4, 0, 0, 0, len, tag);
    step(1'b1, 8'hC4, 1, exp, "R10");
    step(1'b0, 8'h00, 0, '0, "R10");
    step(1'b0, 8'h00, 0, '0, "R10");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule